// File: doc/BRIEF.md
# Cipher Operand Bypass Selector

This block sits in front of a two-round cipher step inside a pipelined core. It gives the cipher the current 64-bit data block and the four 32-bit key words. The cipher registers can lag behind the instruction stream while register loads are still moving through the execute, memory and write-back stages. The block resolves each of the six cipher registers to the newest value in flight. It is purely combinational.

Three candidates can compete for a register: a pending write from each of the three later stages. Each one carries an address, a data word, a valid flag and an instruction-kind tag. The selector only accepts writes whose kind is one of the two register-loading XOR operations. A ciphertext block that the last cipher step has just produced outranks every plaintext source for the two block registers. The key words never see that ciphertext.

Top module: `op_fwd_unit`

## Requirements
- R1: Register 0 drives the upper 32 bits of `blk_out` and register 1 the lower 32 bits. Registers 2 to 5 drive `key_out[0]` to `key_out[3]` in that order. Each register reads its default value from `rf_q[r]`.
- R2: When no pending write applies to a register, and no ciphertext applies to it, the output word equals the stored word `rf_q[r]`.
- R3: A pending write applies to register r only when two things hold: its valid bit is 1, and its 4-bit address equals r exactly. Addresses 6 to 15 change no output.
- R4: A pending write is eligible only when its 3-bit kind tag is 1 (load from two integer operands) or 2 (load from an integer and a cipher operand). Tags 0 and 3 to 7 change no output.
- R5: When several stages hold an applicable write to the same register, index 0 (EX) wins over index 1 (MEM), and MEM wins over index 2 (WB).
- R6: When `ct_valid` is 1, `blk_out` equals `ct_block`, whatever plaintext writes are pending to registers 0 and 1.
- R7: The ciphertext bypass never changes `key_out`.
- R8: Each register is resolved on its own, so writes to different registers that are pending in different stages all take effect at the same time.
- R9: The outputs follow the inputs in the same cycle, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_q | input | 6x32 | Stored contents of cipher registers 0 to 5 |
| pw_valid | input | 3 | Pending-write valid flags, index 0 EX, 1 MEM, 2 WB |
| pw_addr | input | 3x4 | Pending-write target register addresses |
| pw_kind | input | 3x3 | Pending-write instruction-kind tags |
| pw_data | input | 3x32 | Pending-write data words |
| ct_valid | input | 1 | Fresh ciphertext from the last cipher step is present |
| ct_block | input | 64 | Fresh ciphertext, upper word for register 0 |
| blk_out | output | 64 | Resolved data block |
| key_out | output | 4x32 | Resolved key words for registers 2 to 5 |

## Verification
The bench builds the block with its default parameters: 32-bit words, four key words and 4-bit addresses. It draws addresses over the whole 4-bit space and kind tags over the whole 3-bit space. This means out-of-range addresses, foreign tags, collisions between stages on one register and ciphertext overlapping plaintext writes all occur many times in the random phase. Directed cases pin down exact priority, the ignored addresses and tags, and the separation between the key words and the ciphertext.

// File: rtl/opfwd_pkg.sv
// Package: constants shared by the operand bypass selector and its checker.
// Assumes stage indices are ordered from the youngest stage (EX) to the oldest (WB).
package opfwd_pkg;
    localparam int TAG_W   = 3;
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int NBLK    = 2;

    typedef enum logic [TAG_W-1:0] {
        KIND_OTHER   = 3'd0,
        KIND_LOAD_II = 3'd1,
        KIND_LOAD_IC = 3'd2
    } instr_kind_e;

    // Returns true for instruction kinds that load a cipher register.
    function automatic logic kind_loads(input logic [TAG_W-1:0] tag);
        return (tag == KIND_LOAD_II) || (tag == KIND_LOAD_IC);
    endfunction
endpackage

// File: rtl/fwd_hit_detect.sv
// Module: decodes one pipeline stage's pending write into a one-hot per-register hit vector.
// Assumes the register count fits in the address space.
module fwd_hit_detect
    import opfwd_pkg::*;
#(
    parameter int NREG   = 6,
    parameter int ADDR_W = 4
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  kind,
    output logic [NREG-1:0]   hit
);
    logic eligible;

    // Purpose: the write counts only if it is valid and carries a register-loading kind.
    always_comb eligible = valid && kind_loads(kind);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign hit[r] = eligible && (addr == ADDR_W'(r));
    end
endmodule

// File: rtl/fwd_word_pick.sv
// Module: priority selection of one register word among the stored value, stage writes and bypass.
// Assumes stage index 0 is the youngest; the bypass outranks every stage.
module fwd_word_pick #(
    parameter int DATA_W = 32,
    parameter int NSTG   = 3
) (
    input  logic [DATA_W-1:0]            rf_word,
    input  logic [NSTG-1:0]              stg_hit,
    input  logic [NSTG-1:0][DATA_W-1:0]  stg_data,
    input  logic                         byp_valid,
    input  logic [DATA_W-1:0]            byp_word,
    output logic [DATA_W-1:0]            word
);
    // Purpose: walk from the oldest source to the youngest so the youngest overrides.
    always_comb begin
        word = rf_word;
        for (int s = NSTG - 1; s >= 0; s--) begin
            if (stg_hit[s]) word = stg_data[s];
        end
        if (byp_valid) word = byp_word;
    end
endmodule

// File: rtl/op_fwd_unit.sv
// Module: combinational bypass selector for the cipher's data block and key words.
// Assumes register 0/1 hold the block (upper/lower) and registers 2.. hold key words.
module op_fwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NKEY   = 4,
    parameter int ADDR_W = 4,
    parameter int NSTG   = 3,
    localparam int NREG  = NBLK + NKEY
) (
    input  logic [NREG-1:0][DATA_W-1:0]  rf_q,
    input  logic [NSTG-1:0]              pw_valid,
    input  logic [NSTG-1:0][ADDR_W-1:0]  pw_addr,
    input  logic [NSTG-1:0][TAG_W-1:0]   pw_kind,
    input  logic [NSTG-1:0][DATA_W-1:0]  pw_data,
    input  logic                         ct_valid,
    input  logic [NBLK*DATA_W-1:0]       ct_block,
    output logic [NBLK*DATA_W-1:0]       blk_out,
    output logic [NKEY-1:0][DATA_W-1:0]  key_out
);
    logic [NSTG-1:0][NREG-1:0]   hit_by_stage;
    logic [NREG-1:0][NSTG-1:0]   hit_by_reg;
    logic [NREG-1:0][DATA_W-1:0] resolved;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        fwd_hit_detect #(.NREG(NREG), .ADDR_W(ADDR_W)) i_hit (
            .valid (pw_valid[s]),
            .addr  (pw_addr[s]),
            .kind  (pw_kind[s]),
            .hit   (hit_by_stage[s])
        );
        for (genvar r = 0; r < NREG; r++) begin : g_tr
            assign hit_by_reg[r][s] = hit_by_stage[s][r];
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_word
        logic              byp_v;
        logic [DATA_W-1:0] byp_w;
        if (r < NBLK) begin : g_blk
            assign byp_v = ct_valid;
            assign byp_w = ct_block[(NBLK-r)*DATA_W-1 -: DATA_W];
        end else begin : g_key
            assign byp_v = 1'b0;
            assign byp_w = '0;
        end
        fwd_word_pick #(.DATA_W(DATA_W), .NSTG(NSTG)) i_pick (
            .rf_word   (rf_q[r]),
            .stg_hit   (hit_by_reg[r]),
            .stg_data  (pw_data),
            .byp_valid (byp_v),
            .byp_word  (byp_w),
            .word      (resolved[r])
        );
    end

    for (genvar r = 0; r < NBLK; r++) begin : g_blk_out
        assign blk_out[(NBLK-r)*DATA_W-1 -: DATA_W] = resolved[r];
    end
    for (genvar k = 0; k < NKEY; k++) begin : g_key_out
        assign key_out[k] = resolved[NBLK+k];
    end
endmodule

// File: rtl/op_fwd_unit_chk.sv
// Module: assertion checker for the operand bypass selector, bound to the top.
// Assumes combinational settling; checks run as immediate assertions on settled values.
module op_fwd_unit_chk
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NKEY   = 4,
    parameter int ADDR_W = 4,
    parameter int NSTG   = 3,
    localparam int NREG  = NBLK + NKEY
) (
    input logic [NREG-1:0][DATA_W-1:0]  rf_q,
    input logic [NSTG-1:0]              pw_valid,
    input logic [NSTG-1:0][ADDR_W-1:0]  pw_addr,
    input logic [NSTG-1:0][TAG_W-1:0]   pw_kind,
    input logic [NSTG-1:0][DATA_W-1:0]  pw_data,
    input logic                         ct_valid,
    input logic [NBLK*DATA_W-1:0]       ct_block,
    input logic [NBLK*DATA_W-1:0]       blk_out,
    input logic [NKEY-1:0][DATA_W-1:0]  key_out
);
    logic [NREG-1:0][DATA_W-1:0] got;

    // Purpose: gather the output words back into register order.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            if (r < NBLK) got[r] = blk_out[(NBLK-r)*DATA_W-1 -: DATA_W];
            else          got[r] = key_out[r-NBLK];
        end
    end

    // Purpose: relate each output word to the candidates visible at the ports.
    always_comb begin
        if (ct_valid) begin
            a_r6_ct_override: assert (blk_out == ct_block);
        end
        for (int r = 0; r < NREG; r++) begin
            logic any_hit;
            logic legal;
            logic ct_here;
            any_hit = 1'b0;
            ct_here = ct_valid && (r < NBLK);
            legal   = (got[r] == rf_q[r]) ||
                      (ct_here && got[r] == ct_block[(NBLK-r)*DATA_W-1 -: DATA_W]);
            for (int s = 0; s < NSTG; s++) begin
                if (pw_valid[s] && kind_loads(pw_kind[s]) && pw_addr[s] == ADDR_W'(r)) begin
                    any_hit = 1'b1;
                    if (got[r] == pw_data[s]) legal = 1'b1;
                end
            end
            if (!any_hit && !ct_here) begin
                a_r2_rf_pass: assert (got[r] == rf_q[r]);
            end
            if (!ct_here && pw_valid[STG_EX] && kind_loads(pw_kind[STG_EX]) &&
                pw_addr[STG_EX] == ADDR_W'(r)) begin
                a_r5_ex_first: assert (got[r] == pw_data[STG_EX]);
            end
            a_r4_legal_source: assert (legal);
        end
    end
endmodule

bind op_fwd_unit op_fwd_unit_chk #(
    .DATA_W(DATA_W), .NKEY(NKEY), .ADDR_W(ADDR_W), .NSTG(NSTG)
) i_chk (
    .rf_q(rf_q), .pw_valid(pw_valid), .pw_addr(pw_addr), .pw_kind(pw_kind),
    .pw_data(pw_data), .ct_valid(ct_valid), .ct_block(ct_block),
    .blk_out(blk_out), .key_out(key_out)
);

// File: tb/test_op_fwd_unit.sv
// Bench: directed corners plus seeded random vectors against a bench-side model.
module test_op_fwd_unit;
    localparam int DATA_W = 32;
    localparam int NKEY   = 4;
    localparam int ADDR_W = 4;
    localparam int NSTG   = 3;
    localparam int NREG   = NKEY + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NREG-1:0][DATA_W-1:0] rf_q;
    logic [NSTG-1:0]             pw_valid;
    logic [NSTG-1:0][ADDR_W-1:0] pw_addr;
    logic [NSTG-1:0][2:0]        pw_kind;
    logic [NSTG-1:0][DATA_W-1:0] pw_data;
    logic                        ct_valid;
    logic [2*DATA_W-1:0]         ct_block;
    logic [2*DATA_W-1:0]         blk_out;
    logic [NKEY-1:0][DATA_W-1:0] key_out;

    op_fwd_unit #(.DATA_W(DATA_W), .NKEY(NKEY), .ADDR_W(ADDR_W), .NSTG(NSTG)) i_op_fwd_unit (
        .rf_q(rf_q), .pw_valid(pw_valid), .pw_addr(pw_addr), .pw_kind(pw_kind),
        .pw_data(pw_data), .ct_valid(ct_valid), .ct_block(ct_block),
        .blk_out(blk_out), .key_out(key_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model: newest eligible value for register r, built from the requirements.
    function automatic logic [DATA_W-1:0] model(input int r);
        logic [DATA_W-1:0] v;
        v = rf_q[r];
        for (int s = NSTG - 1; s >= 0; s--)
            if (pw_valid[s] && (pw_kind[s] == 3'd1 || pw_kind[s] == 3'd2) && pw_addr[s] == r)
                v = pw_data[s];
        if (ct_valid && r == 0) v = ct_block[2*DATA_W-1:DATA_W];
        if (ct_valid && r == 1) v = ct_block[DATA_W-1:0];
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] out_word(input int r);
        if (r == 0) return blk_out[2*DATA_W-1:DATA_W];
        if (r == 1) return blk_out[DATA_W-1:0];
        return key_out[r-2];
    endfunction

    task automatic check(input string req, input int r, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (out_word(r) !== exp) begin
            n_bad++;
            $display("FAIL %s reg%0d got %h exp %h", req, r, out_word(r), exp);
        end
    endtask

    task automatic clear();
        for (int r = 0; r < NREG; r++) rf_q[r] = DATA_W'(32'h1000_0000 + r * 32'h0101_0101);
        pw_valid = '0; pw_addr = '0; pw_kind = '0; pw_data = '0;
        ct_valid = 1'b0; ct_block = '0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rf_q = '0; pw_valid = '0; pw_addr = '0; pw_kind = '0; pw_data = '0;
        ct_valid = 1'b0; ct_block = '0;
        settle();
        for (int r = 0; r < NREG; r++) check("R2 reset", r, '0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1: register-to-output mapping with stored values only.
        @(posedge clk); clear(); settle();
        for (int r = 0; r < NREG; r++) check("R1", r, DATA_W'(32'h1000_0000 + r * 32'h0101_0101));

        // R3: invalid write and out-of-range addresses ignored.
        @(posedge clk); clear();
        pw_valid = 3'b110; pw_kind = {3'd1, 3'd1, 3'd1};
        pw_addr = {4'd6, 4'd14, 4'd2}; pw_data = {32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003};
        settle();
        for (int r = 0; r < NREG; r++) check("R3", r, DATA_W'(32'h1000_0000 + r * 32'h0101_0101));

        // R4: foreign tags ignored, tags 1 and 2 applied.
        for (int t = 0; t < 8; t++) begin
            @(posedge clk); clear();
            pw_valid = 3'b001; pw_addr[0] = 4'd4; pw_kind[0] = 3'(t); pw_data[0] = 32'hD00D_0000 + t;
            settle();
            check("R4", 4, (t == 1 || t == 2) ? 32'hD00D_0000 + t : rf_q[4]);
        end

        // R5: all three stages target register 3.
        @(posedge clk); clear();
        pw_valid = 3'b111; pw_kind = {3'd2, 3'd1, 3'd2}; pw_addr = {4'd3, 4'd3, 4'd3};
        pw_data = {32'h3333_0002, 32'h3333_0001, 32'h3333_0000};
        settle(); check("R5 ex", 3, 32'h3333_0000);
        @(posedge clk); pw_valid = 3'b110; settle(); check("R5 mem", 3, 32'h3333_0001);
        @(posedge clk); pw_valid = 3'b100; settle(); check("R5 wb", 3, 32'h3333_0002);

        // R6 and R7: ciphertext overrides block writes, leaves keys untouched.
        @(posedge clk); clear();
        pw_valid = 3'b111; pw_kind = {3'd1, 3'd1, 3'd1}; pw_addr = {4'd2, 4'd1, 4'd0};
        pw_data = {32'h2222_2222, 32'h1111_1111, 32'h0000_0000};
        ct_valid = 1'b1; ct_block = 64'hFEED_FACE_CAFE_BEEF;
        settle();
        check("R6", 0, 32'hFEED_FACE); check("R6", 1, 32'hCAFE_BEEF);
        check("R7", 2, 32'h2222_2222);
        for (int r = 3; r < NREG; r++) check("R7", r, rf_q[r]);

        // R8 and R9: independent registers resolve together in the same cycle.
        @(posedge clk); clear();
        pw_valid = 3'b111; pw_kind = {3'd2, 3'd1, 3'd2}; pw_addr = {4'd5, 4'd0, 4'd3};
        pw_data = {32'h5555_5555, 32'h0A0A_0A0A, 32'h3C3C_3C3C};
        #1;
        check("R9", 3, 32'h3C3C_3C3C);
        settle();
        check("R8", 0, 32'h0A0A_0A0A); check("R8", 5, 32'h5555_5555); check("R8", 1, rf_q[1]);

        // Random phase: all requirements against the model.
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            for (int r = 0; r < NREG; r++) rf_q[r] = $urandom;
            for (int s = 0; s < NSTG; s++) begin
                pw_valid[s] = ($urandom % 4) != 0;
                pw_addr[s]  = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % NREG);
                pw_kind[s]  = ($urandom % 2) ? 3'($urandom) : 3'(1 + $urandom % 2);
                pw_data[s]  = $urandom;
            end
            ct_valid = ($urandom % 4) == 0;
            ct_block = {32'($urandom), 32'($urandom)};
            settle();
            for (int r = 0; r < NREG; r++) check("R2-random", r, model(r));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule